// File: doc/BRIEF.md
# Chunked SPI Transaction Sequencer

This block sits between a host-side request port and a 32-bit word-level SPI shifter. It serves a peripheral that accepts only a bounded amount of payload per command. A request gives a direction, an address mode, a 17-bit byte address and a byte count. The sequencer cuts the request into chunks of at most `MAX_CHUNK` bytes and sends a fresh command word ahead of each chunk. It moves the payload through byte-wide valid/ready streams, one for each direction.

A write chunk is the command word followed by the packed payload words, all inside one chip-select window. A read chunk first sends the command word and clocks in a short run of busy words. When the last busy word reports ready, chip select drops for one cycle and a separate data window fetches the payload. When it does not report ready, the sequencer hands the wait to an external poller. If that poller gives up, the current chunk is returned as zeros, the remaining chunks are skipped and an error flag is raised.

Top module: `chunk_xfer_seq`

## Requirements
- R1: Each command word has bit 31 = 0, bit 30 = 1 for read and 0 for write, bit 29 = 1 for fixed address, the chunk byte count in bits 28:17, and the chunk start address in bits 16:0.
- R2: A request is split into chunks of `MAX_CHUNK` (4092) bytes each, except that the last chunk carries the remainder.
- R3: Without the fixed flag, each chunk address is the previous one plus the previous chunk length. With the fixed flag, every chunk uses the request address.
- R4: A read chunk sends its command word, then clocks in `BUSY_WORDS` (2) words. When bit 0 of the last of these is 1, it fetches ceil(len/4) data words. Data bytes leave in order, with bits 31:24 of each word first, and padding bytes beyond the chunk length are discarded.
- R5: When bit 0 of the last busy word is 0, `pollReq` rises while chip select is low. The data window starts only after `pollDone`.
- R6: On `pollTimeout`, the current chunk is delivered as zero bytes on the read stream, no further chunk is issued, and `err` is high when `done` pulses. `err` clears when the next request is accepted.
- R7: A write chunk sends its command word and then the data words inside the same chip-select window, with no busy words. Bytes are packed with the first byte in bits 31:24, and the last word is zero-padded.
- R8: A request of length 0 raises `done` in the cycle after `start`, with no SPI word and no chip-select activity.
- R9: Chip select goes low between the busy phase and the data phase of a read chunk, and between consecutive chunks.
- R10: `busy` is high from the cycle after an accepted `start` until `done`. A `start` while `busy` is high has no effect.
- R11: `spiReq` stays high with `spiTxWord` unchanged until `spiAck`, and `spiReq` is only high while `spiCs` is high.
- R12: `rdValid` stays high with `rdData` unchanged until `rdReady`. `rdValid` and `wrReady` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, taken only while idle |
| isRead | input | 1 | 1 = read request, 0 = write request |
| fixedAddr | input | 1 | 1 = every chunk uses the same address |
| addrIn | input | 17 | Request byte address |
| lenIn | input | LEN_W | Request byte count |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last request aborted by a poller timeout |
| wrData | input | 8 | Write payload byte |
| wrValid | input | 1 | Write byte offered |
| wrReady | output | 1 | Write byte taken |
| rdData | output | 8 | Read payload byte |
| rdValid | output | 1 | Read byte offered |
| rdReady | input | 1 | Read byte taken |
| spiCs | output | 1 | Chip select, active high |
| spiReq | output | 1 | Request one 32-bit word exchange |
| spiTxWord | output | 32 | Word to shift out |
| spiAck | input | 1 | Word exchange complete this cycle |
| spiRxWord | input | 32 | Word shifted in, valid with spiAck |
| pollReq | output | 1 | Ask the external poller to wait for ready |
| pollDone | input | 1 | Poller saw ready |
| pollTimeout | input | 1 | Poller gave up |

## Verification
Suppose the remaining-length or address register is corrupted. The next command word then shows a wrong length or address field as soon as chip select rises for the following chunk, so one chunk boundary is enough to expose it. A corrupted byte counter in the shift register shows within one word: bytes are reordered, dropped or duplicated on the read stream, or the peripheral receives a misplaced byte. A wrong controller state shows within one cycle as `spiReq` without chip select, a poll request with chip select high, or a missing one-cycle select gap. Those cases are watched continuously; the rest are caught by comparing the full command log and byte streams after each request.

// File: rtl/chunk_xfer_pkg.sv
package chunk_xfer_pkg;
  localparam int ADDR_W = 17;
  localparam int CLEN_W = 12;
  localparam int WORD_W = 32;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CMD, ST_BUSYW, ST_POLL, ST_GAP,
    ST_XFER, ST_BYTES, ST_FILL, ST_NEXT, ST_DONE
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;
    logic loadChunk;
    logic advance;
    logic captureWord;
    logic popByte;
    logic pushByte;
    logic dropByte;
    logic clearWord;
    logic setErr;
    logic zeroOut;
    logic selCmd;
    logic selData;
  } dpCtl_t;

  typedef struct packed {
    logic chunkEmpty;
    logic wordEmpty;
    logic wordFull;
    logic lastChunk;
  } dpSts_t;
endpackage

// File: rtl/chunk_xfer_dp.sv
module chunk_xfer_dp import chunk_xfer_pkg::*; #(
  parameter int LEN_W     = 16,
  parameter int MAX_CHUNK = 4092
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              isReadIn,
  input  logic              fixedIn,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [LEN_W-1:0]  lenIn,
  input  logic [7:0]        wrData,
  input  logic [WORD_W-1:0] spiRxWord,
  output logic [WORD_W-1:0] spiTxWord,
  output logic [7:0]        rdByte,
  output dpSts_t            sts,
  output logic              rdMode,
  output logic              errFlag
);
  localparam int CNT_W = $clog2(MAX_CHUNK + 1);

  logic [ADDR_W-1:0] curAddr;
  logic [LEN_W-1:0]  remLen;
  logic [CNT_W-1:0]  chunkRem;
  logic [CNT_W-1:0]  chunkLen;
  logic [WORD_W-1:0] shiftQ;
  logic [2:0]        byteCnt;
  logic              fixedQ;
  logic              readQ;
  logic              errQ;
  logic [5:0]        alignSh;
  logic [WORD_W-1:0] cmdWord;
  logic [WORD_W-1:0] dataWord;

  assign chunkLen = (remLen > LEN_W'(MAX_CHUNK)) ? CNT_W'(MAX_CHUNK) : CNT_W'(remLen);
  assign cmdWord  = {1'b0, readQ, fixedQ, CLEN_W'(chunkLen), curAddr};
  assign alignSh  = {3'd4 - byteCnt, 3'b000};
  assign dataWord = shiftQ << alignSh;

  always_comb begin
    spiTxWord = '0;
    if (ctl.selCmd)       spiTxWord = cmdWord;
    else if (ctl.selData) spiTxWord = dataWord;
  end

  assign rdByte         = ctl.zeroOut ? 8'h00 : shiftQ[WORD_W-1 -: 8];
  assign sts.chunkEmpty = (chunkRem == '0);
  assign sts.wordEmpty  = (byteCnt == 3'd0);
  assign sts.wordFull   = (byteCnt == 3'd4);
  assign sts.lastChunk  = (remLen <= LEN_W'(MAX_CHUNK));
  assign rdMode         = readQ;
  assign errFlag        = errQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr  <= '0;
      remLen   <= '0;
      chunkRem <= '0;
      shiftQ   <= '0;
      byteCnt  <= '0;
      fixedQ   <= 1'b0;
      readQ    <= 1'b0;
      errQ     <= 1'b0;
    end else begin
      if (ctl.loadReq) begin
        curAddr <= addrIn;
        remLen  <= lenIn;
        fixedQ  <= fixedIn;
        readQ   <= isReadIn;
        errQ    <= 1'b0;
      end
      if (ctl.setErr) errQ <= 1'b1;
      if (ctl.loadChunk) chunkRem <= chunkLen;
      if (ctl.advance) begin
        remLen <= remLen - LEN_W'(chunkLen);
        if (!fixedQ) curAddr <= curAddr + ADDR_W'(chunkLen);
      end
      if (ctl.clearWord) begin
        shiftQ  <= '0;
        byteCnt <= '0;
      end
      if (ctl.captureWord) begin
        shiftQ  <= spiRxWord;
        byteCnt <= (chunkRem >= CNT_W'(4)) ? 3'd4 : chunkRem[2:0];
      end
      if (ctl.popByte) begin
        shiftQ   <= {shiftQ[WORD_W-9:0], 8'h00};
        byteCnt  <= byteCnt - 3'd1;
        chunkRem <= chunkRem - CNT_W'(1);
      end
      if (ctl.pushByte) begin
        shiftQ   <= {shiftQ[WORD_W-9:0], wrData};
        byteCnt  <= byteCnt + 3'd1;
        chunkRem <= chunkRem - CNT_W'(1);
      end
      if (ctl.dropByte) chunkRem <= chunkRem - CNT_W'(1);
    end
  end
endmodule

// File: rtl/chunk_xfer_ctrl.sv
module chunk_xfer_ctrl import chunk_xfer_pkg::*; #(
  parameter int BUSY_WORDS = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   lenZero,
  input  logic   rdMode,
  input  dpSts_t sts,
  input  logic   spiAck,
  input  logic   readyBit,
  input  logic   pollDone,
  input  logic   pollTimeout,
  input  logic   rdReady,
  input  logic   wrValid,
  output dpCtl_t ctl,
  output logic   spiCs,
  output logic   spiReq,
  output logic   rdValid,
  output logic   wrReady,
  output logic   pollReq,
  output logic   busy,
  output logic   done
);
  localparam int BC_W = $clog2(BUSY_WORDS) + 1;

  seqState_t       state, nxt;
  logic [BC_W-1:0] busyIdx;
  logic            busyLast;
  logic            busyInc;
  logic            busyClr;

  assign busyLast = (busyIdx == BC_W'(BUSY_WORDS - 1));
  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_DONE);

  always_comb begin
    ctl     = '0;
    nxt     = state;
    spiCs   = 1'b0;
    spiReq  = 1'b0;
    rdValid = 1'b0;
    wrReady = 1'b0;
    pollReq = 1'b0;
    busyInc = 1'b0;
    busyClr = 1'b0;
    case (state)
      ST_IDLE: if (start) begin
        ctl.loadReq = 1'b1;
        nxt = lenZero ? ST_DONE : ST_CMD;
      end
      ST_CMD: begin
        spiCs = 1'b1;
        spiReq = 1'b1;
        ctl.selCmd = 1'b1;
        if (spiAck) begin
          ctl.loadChunk = 1'b1;
          ctl.clearWord = 1'b1;
          busyClr = 1'b1;
          nxt = rdMode ? ST_BUSYW : ST_BYTES;
        end
      end
      ST_BUSYW: begin
        spiCs = 1'b1;
        spiReq = 1'b1;
        if (spiAck) begin
          if (busyLast) nxt = readyBit ? ST_GAP : ST_POLL;
          else busyInc = 1'b1;
        end
      end
      ST_POLL: begin
        pollReq = 1'b1;
        if (pollTimeout) begin
          ctl.setErr = 1'b1;
          nxt = ST_FILL;
        end else if (pollDone) nxt = ST_GAP;
      end
      ST_GAP: nxt = ST_XFER;
      ST_XFER: begin
        spiCs = 1'b1;
        spiReq = 1'b1;
        ctl.selData = !rdMode;
        if (spiAck) begin
          if (rdMode) ctl.captureWord = 1'b1;
          else ctl.clearWord = 1'b1;
          nxt = ST_BYTES;
        end
      end
      ST_BYTES: begin
        spiCs = 1'b1;
        if (rdMode) begin
          if (sts.wordEmpty) nxt = sts.chunkEmpty ? ST_NEXT : ST_XFER;
          else begin
            rdValid = 1'b1;
            if (rdReady) ctl.popByte = 1'b1;
          end
        end else begin
          if (sts.wordFull || sts.chunkEmpty) nxt = sts.wordEmpty ? ST_NEXT : ST_XFER;
          else begin
            wrReady = 1'b1;
            if (wrValid) ctl.pushByte = 1'b1;
          end
        end
      end
      ST_FILL: begin
        if (sts.chunkEmpty) nxt = ST_DONE;
        else begin
          rdValid = 1'b1;
          ctl.zeroOut = 1'b1;
          if (rdReady) ctl.dropByte = 1'b1;
        end
      end
      ST_NEXT: begin
        ctl.advance = 1'b1;
        nxt = sts.lastChunk ? ST_DONE : ST_CMD;
      end
      ST_DONE: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      busyIdx <= '0;
    end else begin
      state <= nxt;
      if (busyClr) busyIdx <= '0;
      else if (busyInc) busyIdx <= busyIdx + BC_W'(1);
    end
  end
endmodule

// File: rtl/chunk_xfer_seq.sv
module chunk_xfer_seq import chunk_xfer_pkg::*; #(
  parameter int LEN_W      = 16,
  parameter int MAX_CHUNK  = 4092,
  parameter int BUSY_WORDS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              isRead,
  input  logic              fixedAddr,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [LEN_W-1:0]  lenIn,
  output logic              busy,
  output logic              done,
  output logic              err,
  input  logic [7:0]        wrData,
  input  logic              wrValid,
  output logic              wrReady,
  output logic [7:0]        rdData,
  output logic              rdValid,
  input  logic              rdReady,
  output logic              spiCs,
  output logic              spiReq,
  output logic [WORD_W-1:0] spiTxWord,
  input  logic              spiAck,
  input  logic [WORD_W-1:0] spiRxWord,
  output logic              pollReq,
  input  logic              pollDone,
  input  logic              pollTimeout
);
  dpCtl_t ctl;
  dpSts_t sts;
  logic   rdMode;

  chunk_xfer_ctrl #(.BUSY_WORDS(BUSY_WORDS)) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .lenZero(lenIn == '0),
    .rdMode(rdMode), .sts(sts), .spiAck(spiAck), .readyBit(spiRxWord[0]),
    .pollDone(pollDone), .pollTimeout(pollTimeout), .rdReady(rdReady),
    .wrValid(wrValid), .ctl(ctl), .spiCs(spiCs), .spiReq(spiReq),
    .rdValid(rdValid), .wrReady(wrReady), .pollReq(pollReq),
    .busy(busy), .done(done)
  );

  chunk_xfer_dp #(.LEN_W(LEN_W), .MAX_CHUNK(MAX_CHUNK)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .isReadIn(isRead), .fixedIn(fixedAddr),
    .addrIn(addrIn), .lenIn(lenIn), .wrData(wrData), .spiRxWord(spiRxWord),
    .spiTxWord(spiTxWord), .rdByte(rdData), .sts(sts), .rdMode(rdMode),
    .errFlag(err)
  );
endmodule

// File: rtl/chunk_xfer_chk.sv
module chunk_xfer_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [LEN_W-1:0] lenIn,
  input logic             busy,
  input logic             done,
  input logic             err,
  input logic             wrReady,
  input logic [7:0]       rdData,
  input logic             rdValid,
  input logic             rdReady,
  input logic             spiCs,
  input logic             spiReq,
  input logic [31:0]      spiTxWord,
  input logic             spiAck,
  input logic             pollReq
);
  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && !done |=> busy);
  // R10
  done_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);
  // R11
  spi_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    spiReq && !spiAck |=> spiReq && $stable(spiTxWord));
  // R11
  req_in_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    spiReq |-> spiCs);
  // R5
  poll_deselect_chk: assert property (@(posedge clk) disable iff (!rstN)
    pollReq |-> !spiCs);
  // R12
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid && !rdReady |=> rdValid && $stable(rdData));
  // R12
  stream_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rdValid, wrReady}));
  // R8
  zero_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy && (lenIn == '0) |=> done && !spiCs);
  // R6
  err_in_flight_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(err) |-> busy);
endmodule

bind chunk_xfer_seq chunk_xfer_chk #(.LEN_W(LEN_W)) i_chk (
  .clk(clk), .rstN(rstN), .start(start), .lenIn(lenIn), .busy(busy),
  .done(done), .err(err), .wrReady(wrReady), .rdData(rdData),
  .rdValid(rdValid), .rdReady(rdReady), .spiCs(spiCs), .spiReq(spiReq),
  .spiTxWord(spiTxWord), .spiAck(spiAck), .pollReq(pollReq)
);

// File: tb/test_chunk_xfer_seq.sv
`timescale 1ns/1ps
module test_chunk_xfer_seq;
  localparam int BW = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0, isRead = 1'b0, fixedAddr = 1'b0;
  logic [16:0] addrIn = '0;
  logic [15:0] lenIn = '0;
  logic        busy, done, err;
  logic [7:0]  wrData = '0;
  logic        wrValid = 1'b0, wrReady;
  logic [7:0]  rdData;
  logic        rdValid, rdReady = 1'b1;
  logic        spiCs, spiReq, spiAck = 1'b0;
  logic [31:0] spiTxWord, spiRxWord = '0;
  logic        pollReq, pollDone = 1'b0, pollTimeout = 1'b0;

  always #5 clk = ~clk;

  chunk_xfer_seq i_chunk_xfer_seq (
    .clk(clk), .rstN(rstN), .start(start), .isRead(isRead), .fixedAddr(fixedAddr),
    .addrIn(addrIn), .lenIn(lenIn), .busy(busy), .done(done), .err(err),
    .wrData(wrData), .wrValid(wrValid), .wrReady(wrReady), .rdData(rdData),
    .rdValid(rdValid), .rdReady(rdReady), .spiCs(spiCs), .spiReq(spiReq),
    .spiTxWord(spiTxWord), .spiAck(spiAck), .spiRxWord(spiRxWord),
    .pollReq(pollReq), .pollDone(pollDone), .pollTimeout(pollTimeout)
  );

  int total = 0, fails = 0;
  bit finished = 0;
  // bench-side models
  int clrReq = 0, clrSeen = 0;
  int cmdCnt, segCnt, wrCnt, rdCnt, rdGen, doneCnt, busyWords, pollSeen, pollCsBad;
  int wordIdx, mRdLeft, mWrLeft, wrIdx, pollCnt;
  bit dataPend, dataSeg, mRd, csPrev = 0, errAtDone;
  bit busyOk = 1, pollFail = 0, rdStall = 0, wrStall = 0;
  logic [31:0] cmdLog [0:7];
  logic [7:0]  wrLog [0:8191];
  logic [7:0]  rdLog [0:8191];

  function automatic logic [7:0] rdGenByte(int k);
    return 8'((k * 29 + 7) ^ (k >> 5));
  endfunction
  function automatic logic [7:0] wrSrcByte(int k);
    return 8'(k * 13 + 5);
  endfunction
  function automatic logic [31:0] mkCmd(bit rd, bit fx, int len, int addr);
    return {1'b0, rd, fx, 12'(len), 17'(addr)};
  endfunction

  always @(negedge clk) begin
    if (clrReq != clrSeen) begin
      clrSeen = clrReq; cmdCnt = 0; segCnt = 0; wrCnt = 0; rdCnt = 0; rdGen = 0;
      doneCnt = 0; busyWords = 0; pollSeen = 0; pollCsBad = 0; dataPend = 0;
      dataSeg = 0; wordIdx = 0; wrIdx = 0; mRdLeft = 0; mWrLeft = 0; errAtDone = 0;
    end
    if (spiCs && !csPrev) begin
      segCnt++; wordIdx = 0; dataSeg = dataPend; dataPend = 0;
    end
    csPrev = spiCs;
    // word-level SPI peripheral
    if (spiAck) spiAck = 1'b0;
    else if (spiReq) begin
      spiAck = 1'b1;
      spiRxWord = '0;
      if (dataSeg) begin
        for (int i = 0; i < 4; i++)
          if (mRdLeft > 0) begin
            spiRxWord[31 - 8*i -: 8] = rdGenByte(rdGen); rdGen++; mRdLeft--;
          end
      end else if (wordIdx == 0) begin
        if (cmdCnt < 8) cmdLog[cmdCnt] = spiTxWord;
        cmdCnt++;
        mRd = spiTxWord[30];
        if (mRd) mRdLeft = int'(spiTxWord[28:17]); else mWrLeft = int'(spiTxWord[28:17]);
      end else if (mRd) begin
        busyWords++;
        if (wordIdx == BW) begin spiRxWord[0] = busyOk; dataPend = 1; end
      end else begin
        for (int i = 0; i < 4; i++)
          if (mWrLeft > 0) begin
            wrLog[wrCnt] = spiTxWord[31 - 8*i -: 8]; wrCnt++; mWrLeft--;
          end
      end
      wordIdx++;
    end
    // busy poller
    if (pollDone || pollTimeout) begin pollDone = 0; pollTimeout = 0; pollCnt = 0; end
    else if (pollReq) begin
      pollSeen++; if (spiCs) pollCsBad++;
      pollCnt++;
      if (pollCnt == 3) begin if (pollFail) pollTimeout = 1; else pollDone = 1; end
    end else pollCnt = 0;
    // read sink
    rdReady = rdStall ? ~rdReady : 1'b1;
    if (rdValid && rdReady) begin rdLog[rdCnt] = rdData; rdCnt++; end
    // write source
    wrValid = wrStall ? ~wrValid : 1'b1;
    wrData = wrSrcByte(wrIdx);
    if (wrValid && wrReady) wrIdx++;
    if (done) begin doneCnt++; errAtDone = err; end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic runXfer(input bit rd, input bit fx, input int addr, input int len);
    int n = 0;
    @(negedge clk); clrReq++;
    @(negedge clk);
    isRead = rd; fixedAddr = fx; addrIn = 17'(addr); lenIn = 16'(len); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (doneCnt == 0 && n < 40000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic cmpWrite(input string req, input int len);
    int bad = -1;
    for (int k = 0; k < len; k++) if (bad < 0 && wrLog[k] !== wrSrcByte(k)) bad = k;
    chk(wrCnt == len, req, wrCnt, len);
    chk(bad < 0, req, (bad < 0) ? 0 : wrLog[bad], (bad < 0) ? 0 : wrSrcByte(bad));
  endtask

  task automatic cmpRead(input string req, input int len);
    int bad = -1;
    for (int k = 0; k < len; k++) if (bad < 0 && rdLog[k] !== rdGenByte(k)) bad = k;
    chk(rdCnt == len, req, rdCnt, len);
    chk(bad < 0, req, (bad < 0) ? 0 : rdLog[bad], (bad < 0) ? 0 : rdGenByte(bad));
  endtask

  task automatic tReset();
    chk(busy == 0 && done == 0 && err == 0, "R10 reset idle", {busy, done, err}, 0);
    chk(spiCs == 0 && spiReq == 0, "R11 reset bus quiet", {spiCs, spiReq}, 0);
    chk(rdValid == 0 && wrReady == 0 && pollReq == 0, "R12 reset streams", {rdValid, wrReady, pollReq}, 0);
  endtask

  task automatic tShortWrite();
    busyOk = 1; wrStall = 0;
    runXfer(0, 0, 'h100, 10);
    chk(cmdCnt == 1, "R7 one write command", cmdCnt, 1);
    chk(cmdLog[0] == mkCmd(0, 0, 10, 'h100), "R1 write command word", cmdLog[0], mkCmd(0, 0, 10, 'h100));
    chk(busyWords == 0 && segCnt == 1, "R7 no busy words, one select window", {busyWords, segCnt}, 1);
    cmpWrite("R7 write bytes padded", 10);
    chk(doneCnt == 1 && errAtDone == 0, "R10 single done no err", {doneCnt, errAtDone}, 2);
  endtask

  task automatic tShortRead();
    busyOk = 1; rdStall = 0;
    runXfer(1, 0, 'h1F000, 6);
    chk(cmdLog[0] == mkCmd(1, 0, 6, 'h1F000), "R1 read command word", cmdLog[0], mkCmd(1, 0, 6, 'h1F000));
    chk(busyWords == BW, "R4 busy word count", busyWords, BW);
    chk(segCnt == 2, "R9 select drops before read data", segCnt, 2);
    cmpRead("R4 read bytes in order", 6);
  endtask

  task automatic tLongWrite();
    busyOk = 1; wrStall = 1;
    runXfer(0, 0, 'h10, 4100);
    wrStall = 0;
    chk(cmdCnt == 2, "R2 two chunks", cmdCnt, 2);
    chk(cmdLog[0] == mkCmd(0, 0, 4092, 'h10), "R2 first chunk full", cmdLog[0], mkCmd(0, 0, 4092, 'h10));
    chk(cmdLog[1] == mkCmd(0, 0, 8, 'h10 + 4092), "R3 address advances", cmdLog[1], mkCmd(0, 0, 8, 'h10 + 4092));
    chk(segCnt == 2, "R9 select drops between chunks", segCnt, 2);
    cmpWrite("R11 R7 long write bytes", 4100);
  endtask

  task automatic tLongReadFixed();
    busyOk = 1; rdStall = 1;
    runXfer(1, 1, 'h55, 4093);
    rdStall = 0;
    chk(cmdCnt == 2, "R2 remainder chunk", cmdCnt, 2);
    chk(cmdLog[1] == mkCmd(1, 1, 1, 'h55), "R3 fixed address reused", cmdLog[1], mkCmd(1, 1, 1, 'h55));
    chk(segCnt == 4 && busyWords == 2 * BW, "R9 read chunk windows", {segCnt, busyWords}, {32'd4, 32'(2 * BW)});
    cmpRead("R12 read under backpressure", 4093);
  endtask

  task automatic tZeroLen();
    @(negedge clk); clrReq++;
    @(negedge clk); isRead = 0; lenIn = 0; addrIn = 'h33; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(done == 1, "R8 done next cycle", done, 1);
    @(negedge clk);
    chk(busy == 0, "R8 idle after done", busy, 0);
    repeat (4) @(negedge clk);
    chk(cmdCnt == 0 && segCnt == 0, "R8 no bus activity", {cmdCnt, segCnt}, 0);
  endtask

  task automatic tStartWhileBusy();
    int n = 0;
    busyOk = 1;
    @(negedge clk); clrReq++;
    @(negedge clk); isRead = 0; fixedAddr = 0; addrIn = 'h20; lenIn = 8; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    isRead = 1; addrIn = 'h300; lenIn = 100; start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (doneCnt == 0 && n < 2000) begin @(negedge clk); n++; end
    repeat (30) @(negedge clk);
    chk(cmdCnt == 1 && doneCnt == 1, "R10 start ignored while busy", {cmdCnt, doneCnt}, {32'd1, 32'd1});
    chk(cmdLog[0] == mkCmd(0, 0, 8, 'h20), "R10 original request kept", cmdLog[0], mkCmd(0, 0, 8, 'h20));
  endtask

  task automatic tPollOk();
    busyOk = 0; pollFail = 0;
    runXfer(1, 0, 'h2000, 9);
    chk(pollSeen > 0 && pollCsBad == 0, "R5 poll with select low", pollCsBad, 0);
    chk(errAtDone == 0 && segCnt == 2, "R5 data after poll done", {errAtDone, segCnt}, 2);
    cmpRead("R5 read after poll", 9);
  endtask

  task automatic tPollTimeout();
    int bad = 0;
    busyOk = 0; pollFail = 1;
    runXfer(1, 0, 'h40, 4100);
    for (int k = 0; k < rdCnt; k++) if (rdLog[k] != 0) bad++;
    chk(rdCnt == 4092 && bad == 0, "R6 zero chunk returned", rdCnt, 4092);
    chk(cmdCnt == 1 && segCnt == 1, "R6 later chunks skipped", {cmdCnt, segCnt}, {32'd1, 32'd1});
    chk(errAtDone == 1, "R6 err with done", errAtDone, 1);
    busyOk = 1; pollFail = 0;
    runXfer(0, 0, 'h0, 3);
    chk(errAtDone == 0, "R6 err cleared by next request", errAtDone, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tShortWrite();
    tShortRead();
    tZeroLen();
    tStartWhileBusy();
    tLongWrite();
    tLongReadFixed();
    tPollOk();
    tPollTimeout();
    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #1900000;
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule